// File: doc/BRIEF.md
# Multiplexed Bank Address Latch

This block recovers the upper byte of a 24-bit CPU address from a data bus that the CPU time-shares. While the phase-2 clock is low, the CPU drives address bits 23:16 onto the data lines. While phase-2 is high, the same lines carry the actual read or write data. The block samples the data lines during the low half of a qualified bus cycle and holds the result as the bank byte for the rest of that cycle. It joins this byte to the CPU's 16 low address lines to form a 24-bit physical address that spans 16 MB.

The block runs on a system clock that is faster than phase-2, and it samples phase-2 as a synchronous level. While phase-2 is low, the held bank register follows the data lines, one system clock behind, on every cycle that the CPU marks as valid through either its data-address qualifier or its program-address qualifier. While phase-2 is high, or when neither qualifier is set, the register keeps its value, so a data transfer can never overwrite a bank. A vector fetch needs no special handling: the CPU drives bank 0x00 during that cycle, and the block captures it like any other bank. A bypass input zeroes the bank bits at the output so that the system decodes a plain 16-bit space. The block also tells the rest of the system when the data lines belong to data transfer.

The CPU bus cannot be stalled by this block and offers no back-pressure of its own. For this reason no valid/ready handshake is used. Every qualified low-phase sample is accepted, and the outputs are plain levels.

Top module: `bank_addr_latch`

## Requirements
- R1: While reset is asserted, bank_o is 0x00 and addr_o[23:16] is zero.
- R2: On a system clock edge where phi2_i is low and at least one qualifier is high, the held bank takes dbus_i[7:0]. With bypass low, bank_o shows that value from the following cycle.
- R3: On an edge where phi2_i is high, the held bank keeps its value whatever dbus_i carries.
- R4: On an edge where phi2_i is low and both qualifiers are low, the held bank keeps its value.
- R5: Either qualifier on its own, data-address (vld_data_i) or program-address (vld_prog_i), is enough to allow capture.
- R6: While bank_bypass_i is high, bank_o and addr_o[23:16] are zero in the same cycle. Capture continues unchanged underneath, so the held value appears at once when bypass falls.
- R7: addr_o[15:0] always equals addr_lo_i, and addr_o[23:16] equals bank_o.
- R8: data_phase_o is high exactly when phi2_i is high. This marks the data lines as carrying transfer data rather than a bank value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phase-2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | CPU phase-2 level, synchronous to clk |
| vld_data_i | input | 1 | CPU data-address-valid qualifier |
| vld_prog_i | input | 1 | CPU program-address-valid qualifier |
| dbus_i | input | 8 | Shared CPU data lines |
| addr_lo_i | input | 16 | CPU address lines 15:0 |
| bank_bypass_i | input | 1 | Forces the bank bits to zero (16-bit mode) |
| bank_o | output | 8 | Held bank byte, address bits 23:16 |
| addr_o | output | 24 | Full physical address |
| data_phase_o | output | 1 | High while the data lines carry transfer data |

## Verification
A wrong held bank shows up at bank_o and addr_o[23:16] one system clock after the edge that corrupted it. It stays wrong until the next qualified low-phase sample. For this reason, every step of the bench compares both outputs against a model of the held byte. Data-phase leakage is exposed by driving the complement of the last bank during phase-2 high. Qualifier mistakes are exposed by low-phase steps that present new bytes with the qualifiers cleared. A bypass fault shows up in the same cycle, either as non-zero upper bits or as a lost bank once bypass is released.

// File: rtl/bal_pkg.sv
package bal_pkg;
  // Which half of the CPU cycle the shared lines belong to.
  typedef enum logic {
    PH_ADDR = 1'b0,  // phase-2 low: lines carry the bank byte
    PH_DATA = 1'b1   // phase-2 high: lines carry transfer data
  } bus_phase_e;
endpackage

// File: rtl/bal_phase.sv
module bal_phase
  import bal_pkg::*;
(
  input  logic       phi2_i,
  input  logic       vld_data_i,
  input  logic       vld_prog_i,
  output bus_phase_e phase_o,
  output logic       capture_o
);
  logic cyc_valid;

  always_comb begin
    phase_o   = phi2_i ? PH_DATA : PH_ADDR;
    cyc_valid = vld_data_i | vld_prog_i;
    capture_o = (phase_o == PH_ADDR) && cyc_valid;
  end
endmodule

// File: rtl/bal_bank_hold.sv
module bal_bank_hold #(
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              phi2_i,
  input  logic              vld_any_i,
  input  logic [DATA_W-1:0] dbus_i,
  output logic [BANK_W-1:0] bank_q_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bank_q <= '0;
    else if (capture_i) bank_q <= dbus_i[BANK_W-1:0];
  end

  assign bank_q_o = bank_q;

  // R2: qualified low-phase sample lands in the held bank
  assert_capture_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi2_i && vld_any_i) |=> (bank_q == $past(dbus_i[BANK_W-1:0])));

  // R3: data phase never disturbs the held bank
  assert_hold_data_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phi2_i |=> $stable(bank_q));

  // R4: unqualified low phase keeps the held bank
  assert_hold_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi2_i && !vld_any_i) |=> $stable(bank_q));
endmodule

// File: rtl/bal_addr_join.sv
module bal_addr_join #(
  parameter int BANK_W = 8,
  parameter int LO_W   = 16,
  localparam int FULL_W = BANK_W + LO_W
) (
  input  logic              bypass_i,
  input  logic [BANK_W-1:0] bank_q_i,
  input  logic [LO_W-1:0]   addr_lo_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [FULL_W-1:0] addr_o
);
  for (genvar i = 0; i < BANK_W; i++) begin : g_mask
    assign bank_o[i] = bank_q_i[i] & ~bypass_i;
  end

  assign addr_o = {bank_o, addr_lo_i};
endmodule

// File: rtl/bank_addr_latch.sv
module bank_addr_latch
  import bal_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int DATA_W = 8,
  parameter int LO_W   = 16,
  localparam int FULL_W = BANK_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2_i,
  input  logic              vld_data_i,
  input  logic              vld_prog_i,
  input  logic [DATA_W-1:0] dbus_i,
  input  logic [LO_W-1:0]   addr_lo_i,
  input  logic              bank_bypass_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [FULL_W-1:0] addr_o,
  output logic              data_phase_o
);
  bus_phase_e        phase;
  logic              capture;
  logic [BANK_W-1:0] bank_q;

  bal_phase u_phase (
    .phi2_i     (phi2_i),
    .vld_data_i (vld_data_i),
    .vld_prog_i (vld_prog_i),
    .phase_o    (phase),
    .capture_o  (capture)
  );

  bal_bank_hold #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .phi2_i    (phi2_i),
    .vld_any_i (vld_data_i | vld_prog_i),
    .dbus_i    (dbus_i),
    .bank_q_o  (bank_q)
  );

  bal_addr_join #(.BANK_W(BANK_W), .LO_W(LO_W)) u_join (
    .bypass_i  (bank_bypass_i),
    .bank_q_i  (bank_q),
    .addr_lo_i (addr_lo_i),
    .bank_o    (bank_o),
    .addr_o    (addr_o)
  );

  assign data_phase_o = (phase == PH_DATA);

  // R6: bypass clears the upper address bits
  assert_bypass_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_bypass_i |-> (addr_o[FULL_W-1:LO_W] == '0));

  // R7: without bypass the upper address bits show the held bank
  assert_upper_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_bypass_i |-> (addr_o[FULL_W-1:LO_W] == bank_q));

  // R1: reset leaves the bank cleared
  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (bank_q == '0);
  end
endmodule

// File: tb/bank_addr_latch_tb.sv
module bank_addr_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0, vd = 1'b0, vp = 1'b0, byp = 1'b0;
  logic [7:0]  dbus = 8'h00;
  logic [15:0] lo = 16'h0000;
  logic [7:0]  bank_o;
  logic [23:0] addr_o;
  logic        data_phase_o;

  int checks = 0, errors = 0;
  logic [7:0] model = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  bank_addr_latch u_dut (
    .clk(clk), .rst_n(rst_n), .phi2_i(phi2), .vld_data_i(vd), .vld_prog_i(vp),
    .dbus_i(dbus), .addr_lo_i(lo), .bank_bypass_i(byp),
    .bank_o(bank_o), .addr_o(addr_o), .data_phase_o(data_phase_o)
  );

  task automatic check_outs(input string tag);
    logic [7:0] eb;
    eb = byp ? 8'h00 : model;
    checks++;
    if (bank_o !== eb) begin
      errors++;
      $display("FAIL %s: bank_o=%h expected %h", tag, bank_o, eb);
    end
    checks++;
    if (addr_o !== {eb, lo}) begin
      errors++;
      $display("FAIL %s R7: addr_o=%h expected %h", tag, addr_o, {eb, lo});
    end
    checks++;
    if (data_phase_o !== phi2) begin
      errors++;
      $display("FAIL R8: data_phase_o=%b expected %b", data_phase_o, phi2);
    end
  endtask

  task automatic step(input logic p, input logic d, input logic g,
                      input logic [7:0] v, input logic [15:0] a,
                      input logic b, input string tag);
    @(negedge clk);
    phi2 = p; vd = d; vp = g; dbus = v; lo = a; byp = b;
    @(posedge clk);
    if (!p && (d || g)) model = v;
    #1;
    check_outs(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with nonzero data present
    dbus = 8'hA5; lo = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: capture every byte on data-address cycles, then data phase carries complement
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b1, 1'b0, v[7:0], 16'(v * 257), 1'b0, "R2 capture");
      step(1'b1, 1'b1, 1'b1, ~v[7:0], 16'(v * 3), 1'b0, "R3 data phase hold");
    end

    // R5: program-address qualifier alone; R4: unqualified low phase holds
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b0, 1'b1, 8'(v ^ 8'h5A), 16'(v), 1'b0, "R5 prog-only capture");
      step(1'b0, 1'b0, 1'b0, 8'(v + 17), 16'(~v), 1'b0, "R4 invalid hold");
    end

    // R6: bypass masks output while capture continues beneath
    for (int v = 0; v < 64; v++) begin
      step(1'b0, 1'b1, 1'b0, 8'(v * 5 + 1), 16'hFFFF, 1'b1, "R6 bypass capture");
      step(1'b1, 1'b0, 1'b0, 8'hFF, 16'h8000, 1'b1, "R6 bypass data phase");
      step(1'b1, 1'b0, 1'b0, 8'hFF, 16'h0001, 1'b0, "R6 release shows held");
    end

    // Exhaustive control combos x data patterns x bypass (R2 R3 R4 R5 R6)
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 8; c++)
        for (int v = 0; v < 16; v++)
          step(c[2], c[1], c[0], 8'(v * 17 + c), 16'(c * 4096 + v), b[0],
               "R2 R3 R4 R5 R6 combo sweep");

    // Vector fetch cycle: bank 0x00 driven and captured like any other (R2)
    step(1'b0, 1'b1, 1'b1, 8'h00, 16'hFFFC, 1'b0, "R2 vector bank");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule